// File: doc/BRIEF.md
# External Bus Handover Arbiter

This block decides who drives a shared external memory bus: the local processor core or one outside master. The outside master raises an asynchronous request. The block synchronizes that request and grants the bus only at a safe point in the core's access stream. While the bus is granted, the block turns off every local bus driver. Any core access aimed at external space is then stalled until the outside master lets go.

The core presents at most one external access per cycle. Each access is tagged as a read or a write and may carry a pairing hint. The hint marks a read that the same instruction will follow with a second read, and no grant may come between the two. After the request is withdrawn, the block re-enables the drivers one cycle before the held core access is released. The arbitration path has no reset, so the outside master can take the bus while the core is still held in reset. A configuration input keeps the bus for the core alone.

Top module: `bus_handover`

## Requirements
- R1: With the default two synchronizer stages, `bus_grant` rises at the third rising clock edge after the edge that first samples `ext_req_async` high, provided nothing holds the grant off.
- R2: All five driver enables (`drv_addr_en`, `drv_data_en`, `drv_sel_en`, `drv_rd_en`, `drv_wr_en`) are low in exactly the cycles where `bus_grant` is high, and they fall in the same cycle that `bus_grant` rises.
- R3: While `bus_grant` is high, a core access (`core_acc_valid`=1) is stalled (`core_stall`=1) for as long as it stays presented.
- R4: A read issued with `core_acc_lock`=1 blocks any grant until the next core access has been issued. For a gap of g idle cycles between the two reads, the grant rises at edge g+3 counted from the first read's cycle.
- R5: A read issued without the pairing hint does not delay a grant. A pairing hint on a write (`core_acc_write`=1) has no effect.
- R6: After `ext_req_async` falls, `bus_grant` falls at the third edge. The drivers are on again from that cycle, but a held access stays stalled for one further cycle and proceeds in the cycle after.
- R7: Grants are issued and released while `rst_n` is low. Core accesses are ignored while `rst_n` is low: the core is never stalled and no access is issued.
- R8: `grant_hung` is high only when a core access is presented and held off by a current or just-released grant. It is low when no access is presented, and it falls in the cycle the access proceeds.
- R9: While `core_excl` is 1, no new grant is issued and core accesses proceed. Once `core_excl` returns to 0 with the request still synchronized high, the grant rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset; does not reset arbitration |
| ext_req_async | input | 1 | Asynchronous bus request from the outside master |
| core_excl | input | 1 | 1 = core keeps the bus; requests are not granted |
| core_acc_valid | input | 1 | Core presents an external access this cycle |
| core_acc_write | input | 1 | 1 = write, 0 = read |
| core_acc_lock | input | 1 | On a read: a second read of the same instruction follows |
| core_stall | output | 1 | Presented access is held this cycle |
| bus_grant | output | 1 | Bus handed to the outside master |
| grant_hung | output | 1 | Core access ready but held off by a grant |
| drv_addr_en | output | 1 | Address bus output enable |
| drv_data_en | output | 1 | Data bus output enable |
| drv_sel_en | output | 1 | Memory, boot and I/O select strobe output enable |
| drv_rd_en | output | 1 | Read strobe output enable |
| drv_wr_en | output | 1 | Write strobe output enable |

## Verification
The assertions check the following on every cycle: a grant never starts without a synchronized request, never starts while the core has exclusive use, never coexists with an open read pair, and no core access is issued while the bus is away or in the cycle the grant drops. Only the bench scenarios can show the exact latencies. These are the three-edge grant and release delays, the g+3 deferral of a grant by a paired read for each swept gap, and the extra recovery cycle before a held access runs. The bench scenarios also show that grants behave the same while reset is held.

// File: rtl/bh_pkg.sv
package bh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_RECOV = 2'd2
    } bh_state_e;

    typedef struct packed {
        bh_state_e st;
    } bh_arb_s;

    typedef struct packed {
        logic pair_open;
    } bh_guard_s;
endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // No reset: request handling stays live while the core is in reset.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) chain_q[0] <= din;
        end else begin : g_rest
            always_ff @(posedge clk) chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bh_guard.sv
module bh_guard
    import bh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic acc_write,
    input  logic acc_lock,
    input  logic grant,
    output logic hold
);
    bh_guard_s r_q, r_d;
    logic      opening;

    always_comb begin
        opening = go & acc_lock & ~acc_write;
        r_d     = r_q;
        if (go) r_d.pair_open = opening;
        hold    = r_q.pair_open | opening;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R4: an open read pair and a granted bus never coexist
    assert_pair_excludes_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pair_open |-> !grant);
endmodule

// File: rtl/bh_arb.sv
module bh_arb
    import bh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic excl,
    input  logic hold,
    input  logic acc_valid,
    output logic grant,
    output logic drv_en,
    output logic stall,
    output logic hung,
    output logic go
);
    bh_arb_s r_q, r_d;
    logic    valid_g;

    always_comb begin
        valid_g = acc_valid & rst_n;
        r_d     = r_q;
        case (r_q.st)
            ST_GRANT: if (!req_s) r_d.st = ST_RECOV;
            ST_RECOV: r_d.st = ST_IDLE;
            default:  r_d.st = (req_s && !excl && !hold) ? ST_GRANT : ST_IDLE;
        endcase
        grant  = (r_q.st == ST_GRANT);
        drv_en = ~grant;
        stall  = valid_g & (r_q.st != ST_IDLE);
        hung   = stall;
        go     = valid_g & (r_q.st == ST_IDLE);
    end

    // No reset: the outside master may take the bus during core reset.
    always_ff @(posedge clk) r_q <= r_d;

    assert_grant_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(req_s));
    assert_excl_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> !$past(excl));
    assert_no_access_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !go);
    assert_recover_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |-> (!go && drv_en));
    assert_hung_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hung |-> (acc_valid && !go));
endmodule

// File: rtl/bus_handover.sv
module bus_handover #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_async,
    input  logic core_excl,
    input  logic core_acc_valid,
    input  logic core_acc_write,
    input  logic core_acc_lock,
    output logic core_stall,
    output logic bus_grant,
    output logic grant_hung,
    output logic drv_addr_en,
    output logic drv_data_en,
    output logic drv_sel_en,
    output logic drv_rd_en,
    output logic drv_wr_en
);
    logic req_s, hold, go, drv_en;

    bh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (ext_req_async),
        .dout (req_s)
    );

    bh_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .acc_write (core_acc_write),
        .acc_lock  (core_acc_lock),
        .grant     (bus_grant),
        .hold      (hold)
    );

    bh_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (req_s),
        .excl      (core_excl),
        .hold      (hold),
        .acc_valid (core_acc_valid),
        .grant     (bus_grant),
        .drv_en    (drv_en),
        .stall     (core_stall),
        .hung      (grant_hung),
        .go        (go)
    );

    assign drv_addr_en = drv_en;
    assign drv_data_en = drv_en;
    assign drv_sel_en  = drv_en;
    assign drv_rd_en   = drv_en;
    assign drv_wr_en   = drv_en;
endmodule

// File: tb/sim_bus_handover.sv
module sim_bus_handover;
    logic clk = 1'b0;
    logic rst_n, req, excl, v, w, l;
    logic stall, grant, hung, ea, ed, es, er, ew;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    bus_handover u0 (
        .clk(clk), .rst_n(rst_n), .ext_req_async(req), .core_excl(excl),
        .core_acc_valid(v), .core_acc_write(w), .core_acc_lock(l),
        .core_stall(stall), .bus_grant(grant), .grant_hung(hung),
        .drv_addr_en(ea), .drv_data_en(ed), .drv_sel_en(es),
        .drv_rd_en(er), .drv_wr_en(ew)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acc(input logic vv, input logic ww, input logic ll);
        v = vv; w = ww; l = ll;
    endtask

    task automatic drv_chk(input string tag, input logic exp);
        chk(tag, ea, exp); chk(tag, ed, exp); chk(tag, es, exp);
        chk(tag, er, exp); chk(tag, ew, exp);
    endtask

    // Drop the request from a granted state; pend = access held meanwhile
    task automatic release_bus(input logic pend, input logic in_reset);
        logic exp_st;
        req = 1'b0;
        acc(pend, 1'b0, 1'b0);
        for (int t = 1; t <= 4; t++) begin
            step();
            chk($sformatf("R6 grant release tick %0d", t), grant, (t < 3));
            exp_st = pend && !in_reset && (t <= 3);
            chk($sformatf("R6 stall release tick %0d", t), stall, exp_st);
            chk($sformatf("R8 hung release tick %0d", t), hung, exp_st);
            if (t == 3) drv_chk("R2 R6 drivers back on", 1'b1);
        end
        acc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; excl = 1'b0;
        acc(1'b0, 1'b0, 1'b0);
        repeat (5) step();
        rst_n = 1'b1;
        step();
        chk("R2 reset grant low", grant, 1'b0);
        drv_chk("R2 reset drivers on", 1'b1);
        chk("R8 reset hung low", hung, 1'b0);

        // R1 / R2 baseline latency
        req = 1'b1;
        for (int t = 1; t <= 3; t++) begin
            step();
            chk($sformatf("R1 grant tick %0d", t), grant, (t == 3));
            drv_chk($sformatf("R2 drivers tick %0d", t), (t != 3));
        end
        chk("R8 no access no hung", hung, 1'b0);
        // R3 / R8 stall while granted
        acc(1'b1, 1'b0, 1'b0);
        #1;
        chk("R3 stall while granted", stall, 1'b1);
        chk("R8 hung while granted", hung, 1'b1);
        repeat (2) begin
            step();
            chk("R3 stall held", stall, 1'b1);
        end
        release_bus(1'b1, 1'b0);

        // R4 sweep of the gap between two paired reads
        for (int g = 0; g <= 4; g++) begin
            req = 1'b1;
            for (int k = 0; k <= g + 3; k++) begin
                if (k == 0)          acc(1'b1, 1'b0, 1'b1);
                else if (k == g + 1) acc(1'b1, 1'b0, 1'b0);
                else                 acc(1'b0, 1'b0, 1'b0);
                #1;
                if (k <= g + 1) chk($sformatf("R4 read g%0d k%0d not stalled", g, k), stall, 1'b0);
                step();
                chk($sformatf("R4 gap %0d grant tick %0d", g, k + 1), grant, (k + 1 >= g + 3));
            end
            release_bus(1'b0, 1'b0);
        end

        // R5 unpaired read then write with a hint that must be ignored
        req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (k == 0)      acc(1'b1, 1'b0, 1'b0);
            else if (k == 1) acc(1'b1, 1'b1, 1'b1);
            else             acc(1'b0, 1'b0, 1'b0);
            step();
            chk($sformatf("R5 read-write grant tick %0d", k + 1), grant, (k == 2));
        end
        release_bus(1'b0, 1'b0);

        // R9 exclusive use
        excl = 1'b1; req = 1'b1;
        for (int t = 1; t <= 6; t++) begin
            acc((t == 4), 1'b0, 1'b0);
            #1;
            if (t == 4) chk("R9 access proceeds", stall, 1'b0);
            step();
            chk($sformatf("R9 no grant tick %0d", t), grant, 1'b0);
        end
        acc(1'b0, 1'b0, 1'b0);
        excl = 1'b0;
        step();
        chk("R9 grant after exclusive cleared", grant, 1'b1);
        release_bus(1'b0, 1'b0);

        // R7 grant during reset; accesses ignored
        rst_n = 1'b0; req = 1'b1;
        acc(1'b1, 1'b0, 1'b0);
        for (int t = 1; t <= 3; t++) begin
            step();
            chk($sformatf("R7 reset grant tick %0d", t), grant, (t == 3));
            chk("R7 no stall in reset", stall, 1'b0);
        end
        release_bus(1'b1, 1'b1);
        rst_n = 1'b1;
        step();
        chk("R7 idle after reset", grant, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule